// File: doc/BRIEF.md
# HDLC Receive Frame Filter and Checker

This block sits behind a serial line receiver and finds HDLC frames in the bit stream, taking one bit each time `bit_en` is high. It finds the 0x7E flags and the abort pattern, deletes stuffed zeros, and assembles octets least significant bit first. The first octet of each frame is the station address. It is masked and then compared against a set of programmable address registers. A frame is delivered only if its address matches and a receive buffer is free at the moment the address octet completes. A delivered frame appears on a per-octet data strobe and ends with a single frame-end pulse that carries a status word.

The block does not compute the frame check sequence itself. A separate CRC checker drives `fcs_ok`, which is sampled on the cycle the closing flag is recognised. The block also keeps four wrapping 16-bit statistics counters:

- frames discarded for lack of a buffer;
- frames with a bad check sequence;
- aborted frames;
- frames whose address did not match.

Software may load these counters only while the channel is disabled.

Top module: `hdlc_rx_filter`

## Requirements
- R1: A 0x7E flag (0,1,1,1,1,1,1,0 in line order) closes the open frame and opens the next, so two frames separated by one shared flag are both delivered with their own octets and frame-end pulses.
- R2: Inside a frame, a zero that follows five consecutive ones is removed before octet assembly, so payload octets such as 0xFF and 0x7E are delivered unchanged.
- R3: Seven consecutive ones abort the open frame: no frame-end pulse is produced, and the abort counter increments if the frame had received at least one data bit.
- R4: The first octet is the address; it matches when (address AND `addr_mask`) equals (register AND `addr_mask`) for any of the registers (register i at `addr_regs[8i+7:8i]`); every octet of a matched, buffered frame (address and check-sequence octets included) is strobed on `byte_data`.
- R5: There is no broadcast mode: address 0xFF under a full mask is delivered only when some address register holds 0xFF.
- R6: At frame end of a delivered frame, `frame_end` pulses for one cycle with `fe_status[LEN_W+3:4]` = total complete octets, bit 3 = last-in-frame (always 1), bit 2 = too long, bit 1 = check-sequence error, bit 0 = non-octet aligned; `byte_vld` and `frame_end` are never high together.
- R7: A frame with more complete octets than `max_len` has the too-long bit set, and its length field still holds the full received octet count.
- R8: The check-sequence error bit is the inverse of `fcs_ok` sampled when the closing flag is recognised.
- R9: A frame whose data bit count is not a multiple of eight sets the non-octet bit; the length field counts complete octets only.
- R10: A frame of fewer than 3 complete octets produces no frame-end pulse and changes no counter.
- R11: Counter index 0 (discarded) increments for an error-free frame (good check sequence, octet aligned, not too long) whose address matched while `buf_free` was low at the address octet; such a frame produces no strobes and no frame-end pulse.
- R12: Counter index 3 (no match) increments only for error-free frames whose address did not match; nothing is strobed for them.
- R13: Counter index 1 (check-sequence error) increments for every frame of at least 3 octets with `fcs_ok` low, including frames that do not match the address and frames received while no buffer is free; at most one of counters 0, 1 and 3 moves per frame.
- R14: Counters are 16 bits and wrap from 0xFFFF to 0; `cnt_we` loads counter `cnt_sel` (index 2 = abort) only while `chan_en` is low. While `chan_en` is low the receiver is held idle and produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; low holds the receiver idle and opens counter writes |
| bit_en | input | 1 | Qualifies `bit_in` for one line bit |
| bit_in | input | 1 | Serial line bit |
| addr_regs | input | NUM_ADDR*8 | Station address registers, register i in bits 8i+7:8i |
| addr_mask | input | 8 | Address compare mask |
| max_len | input | LEN_W | Maximum frame length in octets |
| buf_free | input | 1 | A receive buffer is available |
| fcs_ok | input | 1 | Check-sequence verdict from the external CRC checker |
| byte_vld | output | 1 | Octet strobe for a delivered frame |
| byte_data | output | 8 | Received octet |
| frame_end | output | 1 | End of a delivered frame |
| fe_status | output | LEN_W+4 | Length and status flags, valid with `frame_end` |
| cnt_we | input | 1 | Counter load strobe |
| cnt_sel | input | 2 | Counter index to load |
| cnt_wdata | input | CNT_W | Counter load value |
| cnt_discard | output | CNT_W | Frames discarded for lack of a buffer |
| cnt_crc_err | output | CNT_W | Frames with a bad check sequence |
| cnt_abort | output | CNT_W | Aborted frames |
| cnt_nomatch | output | CNT_W | Error-free frames with a nonmatching address |

## Verification
The assertions check the following on every cycle:

- the flag, abort and data-bit events of the deframer are mutually exclusive;
- octet strobes never coincide with a frame-end pulse;
- no delivered frame is shorter than three octets;
- at most one of the discard, check-sequence and no-match counters advances at a time;
- each counter moves by at most one while the channel runs;
- a disabled channel emits nothing.

Only the directed scenarios can show the following, because they depend on the exact bit patterns sent:

- correct destuffing;
- shared-flag back-to-back delivery;
- masked and broadcast address acceptance;
- the length and flag values in the status word;
- which counter a given frame lands in;
- counter wrap after a load.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int OCTET_W   = 8;
  // Destuffed bits that belong to a flag before it is recognised
  localparam int FLAG_LEAD = 7;
  localparam int MIN_OCTS  = 3;
  localparam int NUM_CNT   = 4;
  localparam int CNT_SEL_W = 2;
  localparam int CNT_DISC    = 0;
  localparam int CNT_CRC     = 1;
  localparam int CNT_ABORT   = 2;
  localparam int CNT_NOMATCH = 3;

  // Address equality restricted to the bits the mask keeps
  function automatic logic masked_eq(input logic [OCTET_W-1:0] a,
                                     input logic [OCTET_W-1:0] b,
                                     input logic [OCTET_W-1:0] m);
    return ((a & m) == (b & m));
  endfunction

  // Octets arrive least significant bit first
  function automatic logic [OCTET_W-1:0] lsb_first(input logic [OCTET_W-1:0] sr,
                                                   input logic b);
    return {b, sr[OCTET_W-1:1]};
  endfunction
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_en,
  input  logic bit_in,
  output logic dbit_vld,
  output logic dbit,
  output logic flag_evt,
  output logic abort_evt
);
  localparam int FILL_W = $clog2(FLAG_LEAD + 1);

  logic [2:0]           ones_q;
  logic [FLAG_LEAD-1:0] pipe_q;
  logic [FILL_W-1:0]    fill_q;
  logic                 push;

  // A bit enters the delay line unless it is a stuffed zero, a flag end or part of a long run of ones
  always_comb begin
    push = 1'b0;
    if (bit_en) begin
      if (bit_in) push = (ones_q < 3'd6);
      else        push = (ones_q != 3'd6) && (ones_q != 3'd5);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      ones_q    <= '0;
      pipe_q    <= '0;
      fill_q    <= '0;
      dbit_vld  <= 1'b0;
      dbit      <= 1'b0;
      flag_evt  <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      dbit_vld  <= 1'b0;
      flag_evt  <= 1'b0;
      abort_evt <= 1'b0;
      if (bit_en) begin
        if (bit_in) begin
          if (ones_q == 3'd6) begin
            abort_evt <= 1'b1;
            fill_q    <= '0;
          end
          if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
        end else begin
          ones_q <= '0;
          if (ones_q == 3'd6) begin
            flag_evt <= 1'b1;
            fill_q   <= '0;
          end
        end
      end
      if (push) begin
        pipe_q <= {pipe_q[FLAG_LEAD-2:0], bit_in};
        if (fill_q == FILL_W'(FLAG_LEAD)) begin
          dbit_vld <= 1'b1;
          dbit     <= pipe_q[FLAG_LEAD-1];
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match
  import hdlc_rx_pkg::*;
#(
  parameter int NUM_ADDR = 4
) (
  input  logic [OCTET_W-1:0]          addr,
  input  logic [OCTET_W-1:0]          mask,
  input  logic [NUM_ADDR*OCTET_W-1:0] regs,
  output logic                        hit
);
  logic [NUM_ADDR-1:0] per_reg;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
    assign per_reg[i] = masked_eq(addr, regs[i*OCTET_W +: OCTET_W], mask);
  end

  assign hit = |per_reg;
endmodule

// File: rtl/hdlc_stat_counters.sv
module hdlc_stat_counters
  import hdlc_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CNT-1:0]            inc,
  input  logic                          wr_ok,
  input  logic                          wr_en,
  input  logic [CNT_SEL_W-1:0]          wr_sel,
  input  logic [CNT_W-1:0]              wr_data,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                         q <= '0;
      else if (wr_ok && wr_en && wr_sel == CNT_SEL_W'(i)) q <= wr_data;
      else if (inc[i])                                    q <= q + 1'b1;
    end
    assign cnt[i] = q;
  end
endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
  import hdlc_rx_pkg::*;
#(
  parameter int NUM_ADDR = 4,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chan_en,
  input  logic                          bit_en,
  input  logic                          bit_in,
  input  logic [NUM_ADDR*OCTET_W-1:0]   addr_regs,
  input  logic [OCTET_W-1:0]            addr_mask,
  input  logic [LEN_W-1:0]              max_len,
  input  logic                          buf_free,
  input  logic                          fcs_ok,
  output logic                          byte_vld,
  output logic [OCTET_W-1:0]            byte_data,
  output logic                          frame_end,
  output logic [LEN_W+3:0]              fe_status,
  input  logic                          cnt_we,
  input  logic [CNT_SEL_W-1:0]          cnt_sel,
  input  logic [CNT_W-1:0]              cnt_wdata,
  output logic [CNT_W-1:0]              cnt_discard,
  output logic [CNT_W-1:0]              cnt_crc_err,
  output logic [CNT_W-1:0]              cnt_abort,
  output logic [CNT_W-1:0]              cnt_nomatch
);
  // Deframer events, named for the checker
  logic dbit_vld, dbit, flag_evt, abort_evt;

  hdlc_rx_deframer u_deframer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (chan_en),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .dbit_vld (dbit_vld),
    .dbit     (dbit),
    .flag_evt (flag_evt),
    .abort_evt(abort_evt)
  );

  logic               in_frame_q, hit_q, buf_q;
  logic [2:0]         bitpos_q;
  logic [LEN_W-1:0]   noct_q;
  logic [OCTET_W-1:0] sr_q;
  logic [OCTET_W-1:0] sr_next;
  logic               addr_hit;

  assign sr_next = lsb_first(sr_q, dbit);

  hdlc_addr_match #(.NUM_ADDR(NUM_ADDR)) u_match (
    .addr(sr_next),
    .mask(addr_mask),
    .regs(addr_regs),
    .hit (addr_hit)
  );

  // Frame-level events
  logic take_bit, has_bits, frame_close, good_close, frame_abort;
  logic too_long, misaligned, fcs_bad, clean, accepted;
  logic [NUM_CNT-1:0] cnt_inc;

  assign take_bit    = dbit_vld && in_frame_q;
  assign has_bits    = (bitpos_q != 3'd0) || (noct_q != '0);
  assign frame_close = flag_evt && in_frame_q && has_bits;
  assign good_close  = frame_close && (noct_q >= LEN_W'(MIN_OCTS));
  assign frame_abort = abort_evt && in_frame_q && has_bits;
  assign too_long    = noct_q > max_len;
  assign misaligned  = bitpos_q != 3'd0;
  assign fcs_bad     = !fcs_ok;
  assign clean       = !fcs_bad && !misaligned && !too_long;
  assign accepted    = hit_q && buf_q;

  always_comb begin
    cnt_inc              = '0;
    cnt_inc[CNT_DISC]    = good_close && clean && hit_q && !buf_q;
    cnt_inc[CNT_CRC]     = good_close && fcs_bad;
    cnt_inc[CNT_ABORT]   = frame_abort;
    cnt_inc[CNT_NOMATCH] = good_close && clean && !hit_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !chan_en) begin
      in_frame_q <= 1'b0;
      hit_q      <= 1'b0;
      buf_q      <= 1'b0;
      bitpos_q   <= '0;
      noct_q     <= '0;
      sr_q       <= '0;
      byte_vld   <= 1'b0;
      byte_data  <= '0;
      frame_end  <= 1'b0;
      fe_status  <= '0;
    end else begin
      byte_vld  <= 1'b0;
      frame_end <= 1'b0;
      if (flag_evt) begin
        in_frame_q <= 1'b1;
        bitpos_q   <= '0;
        noct_q     <= '0;
        hit_q      <= 1'b0;
        buf_q      <= 1'b0;
        if (good_close && accepted) begin
          frame_end <= 1'b1;
          fe_status <= {noct_q, 1'b1, too_long, fcs_bad, misaligned};
        end
      end else if (abort_evt) begin
        in_frame_q <= 1'b0;
      end else if (take_bit) begin
        sr_q     <= sr_next;
        bitpos_q <= bitpos_q + 3'd1;
        if (bitpos_q == 3'd7) begin
          noct_q    <= noct_q + LEN_W'(noct_q != '1);
          byte_data <= sr_next;
          if (noct_q == '0) begin
            hit_q    <= addr_hit;
            buf_q    <= buf_free;
            byte_vld <= addr_hit && buf_free;
          end else begin
            byte_vld <= accepted;
          end
        end
      end
    end
  end

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;

  hdlc_stat_counters #(.CNT_W(CNT_W)) u_counters (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (cnt_inc),
    .wr_ok  (!chan_en),
    .wr_en  (cnt_we),
    .wr_sel (cnt_sel),
    .wr_data(cnt_wdata),
    .cnt    (cnt_all)
  );

  assign cnt_discard = cnt_all[CNT_DISC];
  assign cnt_crc_err = cnt_all[CNT_CRC];
  assign cnt_abort   = cnt_all[CNT_ABORT];
  assign cnt_nomatch = cnt_all[CNT_NOMATCH];
endmodule

// File: rtl/hdlc_rx_filter_chk.sv
module hdlc_rx_filter_chk
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     chan_en,
  input logic                     flag_evt,
  input logic                     abort_evt,
  input logic                     dbit_vld,
  input logic                     byte_vld,
  input logic                     frame_end,
  input logic [LEN_W-1:0]         fe_len,
  input logic [NUM_CNT-1:0]       cnt_inc,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
  assert_evt_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_evt, abort_evt, dbit_vld}));

  assert_abort_no_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !frame_end);

  assert_out_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && frame_end));

  assert_min_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> fe_len >= LEN_W'(MIN_OCTS));

  assert_one_class_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_inc[CNT_DISC], cnt_inc[CNT_CRC], cnt_inc[CNT_NOMATCH]}));

  assert_idle_off_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!byte_vld && !frame_end));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_step
    assert_cnt_step_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && $past(chan_en)) |->
        (cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W]) ||
         cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W]) + 1'b1));
  end
endmodule

bind hdlc_rx_filter hdlc_rx_filter_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_en  (chan_en),
  .flag_evt (flag_evt),
  .abort_evt(abort_evt),
  .dbit_vld (dbit_vld),
  .byte_vld (byte_vld),
  .frame_end(frame_end),
  .fe_len   (fe_status[LEN_W+3:4]),
  .cnt_inc  (cnt_inc),
  .cnt_flat (cnt_all)
);

// File: tb/hdlc_rx_filter_tb.sv
module hdlc_rx_filter_tb;
  localparam int NA = 4;
  localparam int LW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, chan_en, bit_en, bit_in, buf_free, fcs_ok, cnt_we;
  logic [NA*8-1:0] addr_regs;
  logic [7:0] addr_mask, byte_data;
  logic [LW-1:0] max_len;
  logic byte_vld, frame_end;
  logic [LW+3:0] fe_status;
  logic [1:0] cnt_sel;
  logic [CW-1:0] cnt_wdata, cnt_discard, cnt_crc_err, cnt_abort, cnt_nomatch;

  hdlc_rx_filter #(.NUM_ADDR(NA), .LEN_W(LW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .bit_en(bit_en), .bit_in(bit_in),
    .addr_regs(addr_regs), .addr_mask(addr_mask), .max_len(max_len),
    .buf_free(buf_free), .fcs_ok(fcs_ok), .byte_vld(byte_vld), .byte_data(byte_data),
    .frame_end(frame_end), .fe_status(fe_status), .cnt_we(cnt_we), .cnt_sel(cnt_sel),
    .cnt_wdata(cnt_wdata), .cnt_discard(cnt_discard), .cnt_crc_err(cnt_crc_err),
    .cnt_abort(cnt_abort), .cnt_nomatch(cnt_nomatch)
  );

  int n_chk = 0, n_bad = 0;
  int rx_n = 0, fe_n = 0, ones = 0;
  int exp_d = 0, exp_c = 0, exp_a = 0, exp_m = 0;
  logic [7:0] rxb [0:63];
  logic [7:0] txb [0:15];
  logic [LW+3:0] last_st;

  always @(negedge clk) begin
    if (byte_vld) begin
      if (rx_n < 64) rxb[rx_n] = byte_data;
      rx_n++;
    end
    if (frame_end) begin
      fe_n++;
      last_st = fe_status;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
  endtask

  task automatic send_flag();
    drv(1'b0);
    for (int i = 0; i < 6; i++) drv(1'b1);
    drv(1'b0);
    ones = 0;
  endtask

  // Transmit-side zero insertion, written independently of the receiver
  task automatic data_bit(input logic b);
    drv(b);
    if (b) ones++; else ones = 0;
    if (ones == 5) begin
      drv(1'b0);
      ones = 0;
    end
  endtask

  task automatic body(input int n, input int extra);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) data_bit(txb[k][i]);
    for (int j = 0; j < extra; j++) data_bit(j % 2 == 0);
  endtask

  task automatic idle_gap();
    for (int i = 0; i < 8; i++) drv(1'b1);
    @(negedge clk);
    bit_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic frame(input int n, input int extra);
    send_flag();
    body(n, extra);
    send_flag();
    idle_gap();
  endtask

  task automatic clear_rx();
    rx_n = 0;
    fe_n = 0;
  endtask

  task automatic chk_cnts(input string tag);
    chk({tag, " discard"}, 32'(cnt_discard), 32'(exp_d));
    chk({tag, " crc"},     32'(cnt_crc_err), 32'(exp_c));
    chk({tag, " abort"},   32'(cnt_abort),   32'(exp_a));
    chk({tag, " nomatch"}, 32'(cnt_nomatch), 32'(exp_m));
  endtask

  task automatic load(input int n, input logic [7:0] a);
    txb[0] = a;
    for (int i = 1; i < n; i++) txb[i] = 8'(8'h31 * i + 8'h07);
  endtask

  task automatic t_reset();
    chk("R14 reset byte_vld", 32'(byte_vld), 0);
    chk("R6 reset frame_end", 32'(frame_end), 0);
    chk_cnts("R14 reset");
  endtask

  task automatic t_basic();
    clear_rx();
    txb[0] = 8'h45; txb[1] = 8'hFF; txb[2] = 8'h7E; txb[3] = 8'h3E;
    txb[4] = 8'hA5; txb[5] = 8'h5A;
    frame(6, 0);
    chk("R2 octet count", 32'(rx_n), 6);
    for (int i = 0; i < 6; i++) chk("R2/R4 octet value", 32'(rxb[i]), 32'(txb[i]));
    chk("R6 one frame end", 32'(fe_n), 1);
    chk("R6 status", 32'(last_st), 32'({16'd6, 4'b1000}));
    chk_cnts("R6 basic");
  endtask

  task automatic t_b2b();
    logic [7:0] b0;
    clear_rx();
    load(4, 8'h13);
    send_flag();
    body(4, 0);
    send_flag();
    load(5, 8'h21);
    b0 = txb[4];
    body(5, 0);
    send_flag();
    idle_gap();
    chk("R1 frame ends", 32'(fe_n), 2);
    chk("R1 octets", 32'(rx_n), 9);
    chk("R1 second addr", 32'(rxb[4]), 32'h21);
    chk("R1 second last octet", 32'(rxb[8]), 32'(b0));
    chk("R1 second status", 32'(last_st), 32'({16'd5, 4'b1000}));
  endtask

  task automatic t_mask();
    clear_rx();
    addr_mask = 8'hF0;
    load(4, 8'h4A);
    frame(4, 0);
    chk("R4 masked match frame end", 32'(fe_n), 1);
    chk("R4 masked match addr octet", 32'(rxb[0]), 32'h4A);
    clear_rx();
    load(4, 8'h55);
    frame(4, 0);
    exp_m++;
    chk("R12 no strobes", 32'(rx_n), 0);
    chk("R12 no frame end", 32'(fe_n), 0);
    chk_cnts("R12 nomatch");
    addr_mask = 8'hFF;
  endtask

  task automatic t_bcast();
    clear_rx();
    load(3, 8'hFF);
    frame(3, 0);
    exp_m++;
    chk("R5 no broadcast", 32'(fe_n), 0);
    chk_cnts("R5 all-ones rejected");
    addr_regs[31:24] = 8'hFF;
    clear_rx();
    frame(3, 0);
    chk("R5 all-ones register", 32'(fe_n), 1);
    chk("R5 all-ones octets", 32'(rx_n), 3);
    addr_regs[31:24] = 8'h77;
  endtask

  task automatic t_toolong();
    clear_rx();
    max_len = 16'd4;
    load(7, 8'h21);
    frame(7, 0);
    chk("R7 octets still strobed", 32'(rx_n), 7);
    chk("R7 status", 32'(last_st), 32'({16'd7, 4'b1100}));
    chk_cnts("R7 too long");
    max_len = 16'd64;
  endtask

  task automatic t_crc();
    clear_rx();
    fcs_ok = 1'b0;
    load(4, 8'h45);
    frame(4, 0);
    exp_c++;
    chk("R8 status", 32'(last_st), 32'({16'd4, 4'b1010}));
    load(4, 8'h99);
    frame(4, 0);
    exp_c++;
    buf_free = 1'b0;
    load(4, 8'h45);
    frame(4, 0);
    exp_c++;
    chk("R13 only one frame end", 32'(fe_n), 1);
    chk_cnts("R13 crc");
    fcs_ok = 1'b1;
    buf_free = 1'b1;
  endtask

  task automatic t_nonoct();
    clear_rx();
    load(4, 8'h13);
    frame(4, 3);
    chk("R9 octets", 32'(rx_n), 4);
    chk("R9 status", 32'(last_st), 32'({16'd4, 4'b1001}));
    chk_cnts("R9 nonoct");
  endtask

  task automatic t_short();
    clear_rx();
    load(2, 8'h45);
    frame(2, 0);
    chk("R10 no frame end", 32'(fe_n), 0);
    fcs_ok = 1'b0;
    frame(2, 0);
    fcs_ok = 1'b1;
    chk_cnts("R10 short");
  endtask

  task automatic t_nobuf();
    clear_rx();
    buf_free = 1'b0;
    load(5, 8'h45);
    frame(5, 0);
    exp_d++;
    chk("R11 no strobes", 32'(rx_n), 0);
    chk("R11 no frame end", 32'(fe_n), 0);
    chk_cnts("R11 discard");
    buf_free = 1'b1;
  endtask

  task automatic t_abort();
    clear_rx();
    load(3, 8'h21);
    send_flag();
    body(3, 0);
    for (int i = 0; i < 8; i++) drv(1'b1);
    idle_gap();
    exp_a++;
    chk("R3 no frame end", 32'(fe_n), 0);
    chk_cnts("R3 abort");
  endtask

  task automatic t_counters();
    @(negedge clk);
    cnt_we = 1'b1; cnt_sel = 2'd2; cnt_wdata = 16'h1234;
    @(negedge clk);
    cnt_we = 1'b0;
    chk("R14 write ignored while enabled", 32'(cnt_abort), 32'(exp_a));
    chan_en = 1'b0;
    @(negedge clk);
    cnt_we = 1'b1; cnt_wdata = 16'hFFFF;
    @(negedge clk);
    cnt_we = 1'b0;
    chk("R14 write while disabled", 32'(cnt_abort), 32'hFFFF);
    clear_rx();
    load(4, 8'h45);
    frame(4, 0);
    chk("R14 disabled receiver silent", 32'(rx_n + fe_n), 0);
    chan_en = 1'b1;
    @(negedge clk);
    load(3, 8'h21);
    send_flag();
    body(3, 0);
    for (int i = 0; i < 8; i++) drv(1'b1);
    idle_gap();
    exp_a = 0;
    chk("R14 wrap to zero", 32'(cnt_abort), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired (R1..all scenarios incomplete)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chan_en = 1'b1; bit_en = 1'b0; bit_in = 1'b1;
    buf_free = 1'b1; fcs_ok = 1'b1; cnt_we = 1'b0; cnt_sel = '0; cnt_wdata = '0;
    addr_regs = {8'h77, 8'h13, 8'h45, 8'h21};
    addr_mask = 8'hFF;
    max_len = 16'd64;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    idle_gap();
    t_basic();
    t_b2b();
    t_mask();
    t_bcast();
    t_toolong();
    t_crc();
    t_nonoct();
    t_short();
    t_nobuf();
    t_abort();
    t_counters();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule